// File: doc/BRIEF.md
# SMBus Protocol Transaction Sequencer

This block turns one launched host command into an ordered series of byte-level bus primitives: a start condition carrying the target address and a direction bit, a byte sent, a byte received, a NACK, and a stop. A bit-level engine below it carries out each primitive and answers over a request/acknowledge handshake. The sequencer picks the series from a 3-bit protocol code, a target address byte, a command byte, two data bytes and an I2C-mode flag. It then returns the received bytes, the received or applied block length, and a sticky device-error flag.

Block payloads live in a 32-entry byte buffer inside the block. Before a block write, the host fills the buffer through a write port. After a block read, the host drains it through a synchronous read port with one cycle of latency. A `done_o` pulse marks the end of every launch, including a launch that is refused.

Top module: `smbus_txn_seq`

## Requirements
- R1: Protocol codes are 0 quick, 1 byte, 2 byte-data, 3 word-data, 4 process call, 5 block, 6 I2C block read. Code 7 sets `dev_err_o` and issues no primitive.
- R2: Every start primitive carries `addr_i[7:1]` in wdata bits [7:1] and the direction in bit 0. A write phase uses 0, a read phase uses 1, and `addr_i[0]=1` selects a read.
- R3: A word write sends the command, then `data0_i` (low byte), then `data1_i` (high byte), then a stop.
- R4: When `dev_err_o` is already set, a launch issues no primitive, `dev_err_o` stays set and `done_o` pulses. Only `err_clr_i` clears it.
- R5: A block read sends a write-direction start and the command, then a read-direction start. The first received byte is the length and is returned on `data0_o`. The data bytes that follow land in buffer entries 0 upward.
- R6: A received length above 32 is taken as zero. After the last received byte comes one NACK primitive and then a stop.
- R7: Protocol 6 sends `data1_i` as the command and reads `data0_i` bytes with no length byte, the count capped at 32. The count read is returned on `data0_o`. Launching protocol 6 as a write sets `dev_err_o` and issues no primitive.
- R8: A block write sends the command, then a length byte equal to `data0_i`, then that many buffer bytes, then a stop. In I2C mode the length byte is omitted.
- R9: In I2C mode a block read receives no length byte. It reads 32 data bytes and returns 32 on `data0_o`.
- R10: A NACK on any start primitive makes the next primitive a stop. The transaction then ends with `dev_err_o` set.
- R11: `prim_op_o` encodes 0 start, 1 send, 2 receive, 3 NACK, 4 stop. A request holds op and wdata stable until acknowledged. A launch while `busy_o` is high is ignored.
- R12: Byte and byte-data reads return the received byte on `data0_o`. Word reads and process calls put the first received byte on `data0_o` and the second on `data1_o`. A process call sends command, data0 and data1, then restarts for reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch pulse, taken only when idle |
| proto_i | input | 3 | Protocol code |
| addr_i | input | 8 | Target address [7:1], read flag [0] |
| cmd_i | input | 8 | Command byte |
| data0_i | input | 8 | Data byte 0 / block length / count |
| data1_i | input | 8 | Data byte 1 / I2C block command |
| i2c_mode_i | input | 1 | Omit block length bytes |
| err_clr_i | input | 1 | Clear the device-error flag |
| buf_we_i | input | 1 | Host write strobe into the block buffer |
| buf_widx_i | input | 5 | Host write index |
| buf_wdata_i | input | 8 | Host write byte |
| buf_ridx_i | input | 5 | Host read index |
| buf_rdata_o | output | 8 | Buffer byte, one cycle after the index |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-launch pulse |
| dev_err_o | output | 1 | Sticky device error |
| data0_o | output | 8 | Received byte 0 / length / count |
| data1_o | output | 8 | Received byte 1 |
| prim_req_o | output | 1 | Primitive request |
| prim_op_o | output | 3 | Primitive code |
| prim_wdata_o | output | 8 | Address+direction or byte to send |
| prim_ack_i | input | 1 | One-cycle primitive completion |
| prim_nack_i | input | 1 | Address not acknowledged, valid with ack on a start |
| prim_rdata_i | input | 8 | Received byte, valid with ack on a receive |

## Verification
The assertions take three things for granted. The primitive engine raises `prim_ack_i` for one cycle per request and only while a request is pending. `prim_nack_i` has meaning only alongside an acknowledge. The host leaves the buffer write port alone while `busy_o` is high, because a write to the entry being sent would change `prim_wdata_o` under a pending request. The bench responder acknowledges at the falling edge only when a request is open, and drops the acknowledge on the next falling edge. The bench fills the buffer only between transactions.

// File: rtl/smbus_seq_pkg.sv
package smbus_seq_pkg;
  localparam int BYTE_W = 8;

  localparam logic [2:0] PR_QUICK     = 3'd0;
  localparam logic [2:0] PR_BYTE      = 3'd1;
  localparam logic [2:0] PR_BYTE_DATA = 3'd2;
  localparam logic [2:0] PR_WORD      = 3'd3;
  localparam logic [2:0] PR_PROC      = 3'd4;
  localparam logic [2:0] PR_BLOCK     = 3'd5;
  localparam logic [2:0] PR_I2C_BLK   = 3'd6;

  localparam logic [2:0] OP_START = 3'd0;
  localparam logic [2:0] OP_SEND  = 3'd1;
  localparam logic [2:0] OP_RECV  = 3'd2;
  localparam logic [2:0] OP_NACK  = 3'd3;
  localparam logic [2:0] OP_STOP  = 3'd4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START_W, ST_CMD, ST_W0, ST_W1, ST_WLEN, ST_WBLK,
    ST_START_R, ST_RLEN, ST_RDATA, ST_NACK, ST_STOP, ST_DONE
  } seq_state_e;
endpackage

// File: rtl/smbus_seq_buf.sv
module smbus_seq_buf #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH),
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    ra_data <= mem[ra_addr];
    rb_data <= mem[rb_addr];
  end
endmodule

// File: rtl/smbus_seq_fsm.sv
module smbus_seq_fsm
  import smbus_seq_pkg::*;
#(
  parameter int BUF_DEPTH = 32,
  parameter int IDX_W     = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [2:0]        proto_i,
  input  logic [7:0]        addr_i,
  input  logic [7:0]        cmd_i,
  input  logic [7:0]        data0_i,
  input  logic [7:0]        data1_i,
  input  logic              i2c_mode_i,
  input  logic              err_clr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              dev_err_o,
  output logic [7:0]        data0_o,
  output logic [7:0]        data1_o,
  output logic              prim_req_o,
  output logic [2:0]        prim_op_o,
  output logic [7:0]        prim_wdata_o,
  input  logic              prim_ack_i,
  input  logic              prim_nack_i,
  input  logic [7:0]        prim_rdata_i,
  output logic              buf_we_o,
  output logic [IDX_W-1:0]  buf_waddr_o,
  output logic [7:0]        buf_wdata_o,
  output logic [IDX_W-1:0]  buf_raddr_o,
  input  logic [7:0]        buf_rdata_i
);
  localparam int CNT_W = IDX_W + 1;
  localparam logic [CNT_W-1:0] MAXN = CNT_W'(BUF_DEPTH);

  seq_state_e       state_q;
  logic [2:0]       proto_q;
  logic [7:0]       addr_q, cmd_q, d0_q, d1_q, res0_q, res1_q;
  logic             i2c_q, err_pend_q, dev_err_q;
  logic [CNT_W-1:0] cnt_q, n_q;
  logic             rd, last, blk_proto;

  function automatic logic [CNT_W-1:0] cap_cnt(input logic [7:0] v);
    return ({24'd0, v} > BUF_DEPTH) ? MAXN : CNT_W'(v);
  endfunction

  function automatic logic [CNT_W-1:0] len_or_zero(input logic [7:0] v);
    return ({24'd0, v} > BUF_DEPTH) ? '0 : CNT_W'(v);
  endfunction

  assign rd        = addr_q[0];
  assign last      = (cnt_q == n_q - 1'b1);
  assign blk_proto = (proto_q == PR_BLOCK) || (proto_q == PR_I2C_BLK);

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign dev_err_o = dev_err_q;
  assign data0_o   = res0_q;
  assign data1_o   = res1_q;

  always_comb begin
    prim_req_o   = 1'b1;
    prim_op_o    = OP_SEND;
    prim_wdata_o = '0;
    case (state_q)
      ST_START_W: begin prim_op_o = OP_START; prim_wdata_o = {addr_q[7:1], 1'b0}; end
      ST_START_R: begin prim_op_o = OP_START; prim_wdata_o = {addr_q[7:1], 1'b1}; end
      ST_CMD:     prim_wdata_o = (proto_q == PR_I2C_BLK) ? d1_q : cmd_q;
      ST_W0:      prim_wdata_o = d0_q;
      ST_W1:      prim_wdata_o = d1_q;
      ST_WLEN:    prim_wdata_o = 8'(n_q);
      ST_WBLK:    prim_wdata_o = buf_rdata_i;
      ST_RLEN,
      ST_RDATA:   prim_op_o = OP_RECV;
      ST_NACK:    prim_op_o = OP_NACK;
      ST_STOP:    prim_op_o = OP_STOP;
      default:    prim_req_o = 1'b0;
    endcase
  end

  // Next-address lookahead keeps the sync buffer read aligned with cnt_q.
  assign buf_raddr_o = IDX_W'((state_q == ST_WBLK && prim_ack_i) ? cnt_q + 1'b1 : cnt_q);
  assign buf_we_o    = (state_q == ST_RDATA) && prim_ack_i && blk_proto;
  assign buf_waddr_o = cnt_q[IDX_W-1:0];
  assign buf_wdata_o = prim_rdata_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      proto_q <= '0; addr_q <= '0; cmd_q <= '0; d0_q <= '0; d1_q <= '0;
      i2c_q <= 1'b0; err_pend_q <= 1'b0; dev_err_q <= 1'b0;
      res0_q <= '0; res1_q <= '0; cnt_q <= '0; n_q <= '0;
    end else begin
      if (err_clr_i) dev_err_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          proto_q <= proto_i; addr_q <= addr_i; cmd_q <= cmd_i;
          d0_q <= data0_i; d1_q <= data1_i; i2c_q <= i2c_mode_i;
          cnt_q <= '0; err_pend_q <= 1'b0;
          n_q <= (proto_i == PR_BYTE) ? CNT_W'(1) : cap_cnt(data0_i);
          if (dev_err_q && !err_clr_i) state_q <= ST_DONE;
          else if (proto_i == 3'd7 || (proto_i == PR_I2C_BLK && !addr_i[0])) begin
            dev_err_q <= 1'b1;
            state_q   <= ST_DONE;
          end else if ((proto_i == PR_QUICK || proto_i == PR_BYTE) && addr_i[0])
            state_q <= ST_START_R;
          else
            state_q <= ST_START_W;
        end
        ST_START_W: if (prim_ack_i) begin
          if (prim_nack_i) begin err_pend_q <= 1'b1; state_q <= ST_STOP; end
          else state_q <= (proto_q == PR_QUICK) ? ST_STOP : ST_CMD;
        end
        ST_CMD: if (prim_ack_i) begin
          case (proto_q)
            PR_BYTE:              state_q <= ST_STOP;
            PR_BYTE_DATA, PR_WORD: state_q <= rd ? ST_START_R : ST_W0;
            PR_PROC:              state_q <= ST_W0;
            PR_BLOCK:
              if (rd)          state_q <= ST_START_R;
              else if (!i2c_q) state_q <= ST_WLEN;
              else             state_q <= (n_q == 0) ? ST_STOP : ST_WBLK;
            default:              state_q <= ST_START_R;
          endcase
        end
        ST_W0: if (prim_ack_i) state_q <= (proto_q == PR_BYTE_DATA) ? ST_STOP : ST_W1;
        ST_W1: if (prim_ack_i) state_q <= (proto_q == PR_PROC) ? ST_START_R : ST_STOP;
        ST_WLEN: if (prim_ack_i) state_q <= (n_q == 0) ? ST_STOP : ST_WBLK;
        ST_WBLK: if (prim_ack_i) begin
          if (last) state_q <= ST_STOP;
          else      cnt_q   <= cnt_q + 1'b1;
        end
        ST_START_R: if (prim_ack_i) begin
          if (prim_nack_i) begin err_pend_q <= 1'b1; state_q <= ST_STOP; end
          else begin
            case (proto_q)
              PR_QUICK: state_q <= ST_STOP;
              PR_BYTE, PR_BYTE_DATA: begin n_q <= CNT_W'(1); state_q <= ST_RDATA; end
              PR_WORD, PR_PROC:      begin n_q <= CNT_W'(2); state_q <= ST_RDATA; end
              PR_BLOCK:
                if (i2c_q) begin
                  n_q <= MAXN; res0_q <= 8'(MAXN); state_q <= ST_RDATA;
                end else state_q <= ST_RLEN;
              default: begin
                res0_q  <= 8'(n_q);
                state_q <= (n_q == 0) ? ST_NACK : ST_RDATA;
              end
            endcase
          end
        end
        ST_RLEN: if (prim_ack_i) begin
          res0_q  <= 8'(len_or_zero(prim_rdata_i));
          n_q     <= len_or_zero(prim_rdata_i);
          state_q <= (len_or_zero(prim_rdata_i) == 0) ? ST_NACK : ST_RDATA;
        end
        ST_RDATA: if (prim_ack_i) begin
          if (proto_q == PR_BYTE || proto_q == PR_BYTE_DATA) res0_q <= prim_rdata_i;
          else if (proto_q == PR_WORD || proto_q == PR_PROC) begin
            if (cnt_q == 0) res0_q <= prim_rdata_i;
            else            res1_q <= prim_rdata_i;
          end
          if (last) state_q <= ST_NACK;
          else      cnt_q   <= cnt_q + 1'b1;
        end
        ST_NACK: if (prim_ack_i) state_q <= ST_STOP;
        ST_STOP: if (prim_ack_i) begin
          dev_err_q <= dev_err_q | err_pend_q;
          state_q   <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (prim_req_o && !prim_ack_i) |=> (prim_req_o && $stable(prim_op_o) && $stable(prim_wdata_o)));
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R6
  len_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RLEN && prim_ack_i) |=> (res0_q <= 8'(BUF_DEPTH)));
  // R6
  nack_then_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (prim_req_o && prim_op_o == OP_NACK && prim_ack_i) |=> (prim_req_o && prim_op_o == OP_STOP));
  // R10
  addr_nack_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (prim_req_o && prim_op_o == OP_START && prim_ack_i && prim_nack_i) |=> (prim_req_o && prim_op_o == OP_STOP));
  // R4
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i && dev_err_o && !err_clr_i) |=> (done_o && dev_err_o && !prim_req_o));
endmodule

// File: rtl/smbus_txn_seq.sv
module smbus_txn_seq
  import smbus_seq_pkg::*;
#(
  parameter int BUF_DEPTH = 32,
  localparam int IDX_W    = $clog2(BUF_DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [2:0]       proto_i,
  input  logic [7:0]       addr_i,
  input  logic [7:0]       cmd_i,
  input  logic [7:0]       data0_i,
  input  logic [7:0]       data1_i,
  input  logic             i2c_mode_i,
  input  logic             err_clr_i,
  input  logic             buf_we_i,
  input  logic [IDX_W-1:0] buf_widx_i,
  input  logic [7:0]       buf_wdata_i,
  input  logic [IDX_W-1:0] buf_ridx_i,
  output logic [7:0]       buf_rdata_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             dev_err_o,
  output logic [7:0]       data0_o,
  output logic [7:0]       data1_o,
  output logic             prim_req_o,
  output logic [2:0]       prim_op_o,
  output logic [7:0]       prim_wdata_o,
  input  logic             prim_ack_i,
  input  logic             prim_nack_i,
  input  logic [7:0]       prim_rdata_i
);
  logic             seq_we;
  logic [IDX_W-1:0] seq_waddr, seq_raddr, mem_waddr;
  logic [7:0]       seq_wdata, seq_rdata, mem_wdata;
  logic             mem_we;

  // Receive path wins the single write port; the host writes only while idle.
  assign mem_we    = seq_we | buf_we_i;
  assign mem_waddr = seq_we ? seq_waddr : buf_widx_i;
  assign mem_wdata = seq_we ? seq_wdata : buf_wdata_i;

  smbus_seq_fsm #(.BUF_DEPTH(BUF_DEPTH), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst(rst), .start_i(start_i), .proto_i(proto_i), .addr_i(addr_i),
    .cmd_i(cmd_i), .data0_i(data0_i), .data1_i(data1_i), .i2c_mode_i(i2c_mode_i),
    .err_clr_i(err_clr_i), .busy_o(busy_o), .done_o(done_o), .dev_err_o(dev_err_o),
    .data0_o(data0_o), .data1_o(data1_o), .prim_req_o(prim_req_o),
    .prim_op_o(prim_op_o), .prim_wdata_o(prim_wdata_o), .prim_ack_i(prim_ack_i),
    .prim_nack_i(prim_nack_i), .prim_rdata_i(prim_rdata_i),
    .buf_we_o(seq_we), .buf_waddr_o(seq_waddr), .buf_wdata_o(seq_wdata),
    .buf_raddr_o(seq_raddr), .buf_rdata_i(seq_rdata)
  );

  smbus_seq_buf #(.DEPTH(BUF_DEPTH), .AW(IDX_W), .DW(BYTE_W)) u_buf (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .ra_addr(seq_raddr), .ra_data(seq_rdata),
    .rb_addr(buf_ridx_i), .rb_data(buf_rdata_o)
  );
endmodule

// File: tb/smbus_txn_seq_bench.sv
module smbus_txn_seq_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 0, i2c_mode_i = 0, err_clr_i = 0, buf_we_i = 0;
  logic [2:0] proto_i = 0;
  logic [7:0] addr_i = 0, cmd_i = 0, data0_i = 0, data1_i = 0, buf_wdata_i = 0;
  logic [4:0] buf_widx_i = 0, buf_ridx_i = 0;
  logic [7:0] buf_rdata_o, data0_o, data1_o, prim_wdata_o;
  logic busy_o, done_o, dev_err_o, prim_req_o;
  logic [2:0] prim_op_o;
  logic prim_ack_i = 0, prim_nack_i = 0;
  logic [7:0] prim_rdata_i = 0;

  int checks = 0, errors = 0;
  logic [2:0] tr_op [128];  logic [7:0] tr_dat [128];  int tr_n = 0;
  logic [2:0] ex_op [128];  logic [7:0] ex_dat [128];  int ex_n = 0;
  logic [7:0] rx_mem [64];  int rx_ptr = 0;
  bit nack_start = 0;

  always #2 clk = ~clk;

  smbus_txn_seq u_smbus_txn_seq (.*);

  initial begin : responder
    forever begin
      @(negedge clk);
      if (prim_req_o && !prim_ack_i) begin
        prim_ack_i  = 1;
        prim_nack_i = (prim_op_o == 3'd0) && nack_start;
        if (prim_op_o == 3'd2) begin prim_rdata_i = rx_mem[rx_ptr]; rx_ptr++; end
        if (tr_n < 128) begin tr_op[tr_n] = prim_op_o; tr_dat[tr_n] = prim_wdata_o; end
        tr_n++;
      end else begin
        prim_ack_i = 0; prim_nack_i = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic ex(input logic [2:0] op, input logic [7:0] d);
    ex_op[ex_n] = op; ex_dat[ex_n] = d; ex_n++;
  endtask

  task automatic chk_trace(input string tag);
    bit ok = (tr_n == ex_n);
    int bad = -1;
    for (int i = 0; i < ex_n && ok; i++)
      if (tr_op[i] != ex_op[i] || (ex_op[i] <= 3'd1 && tr_dat[i] != ex_dat[i])) begin ok = 0; bad = i; end
    if (tr_n != ex_n) chk(0, {tag, " trace length"}, tr_n, ex_n);
    else if (!ok) chk(0, {tag, " trace entry"}, {tr_op[bad], tr_dat[bad]}, {ex_op[bad], ex_dat[bad]});
    else chk(1, tag, 0, 0);
  endtask

  task automatic run(input logic [2:0] p, input logic [7:0] a, c, d0, d1, input logic i2c);
    int w = 0;
    @(negedge clk);
    proto_i = p; addr_i = a; cmd_i = c; data0_i = d0; data1_i = d1; i2c_mode_i = i2c;
    tr_n = 0; rx_ptr = 0; start_i = 1;
    @(negedge clk); start_i = 0;
    while (!done_o && w < 2000) begin @(negedge clk); w++; end
    chk(done_o, "R11 done pulse seen", done_o, 1);
    @(negedge clk);
  endtask

  task automatic clear_err();
    @(negedge clk); err_clr_i = 1; @(negedge clk); err_clr_i = 0;
  endtask

  task automatic buf_wr(input int idx, input logic [7:0] v);
    @(negedge clk); buf_we_i = 1; buf_widx_i = 5'(idx); buf_wdata_i = v;
    @(negedge clk); buf_we_i = 0;
  endtask

  task automatic buf_rd(input int idx, output logic [7:0] v);
    @(negedge clk); buf_ridx_i = 5'(idx); @(negedge clk); v = buf_rdata_o;
  endtask

  task automatic t_reset();
    chk(!busy_o && !done_o && !dev_err_o && !prim_req_o, "R11 reset idle",
        {busy_o, done_o, dev_err_o, prim_req_o}, 0);
  endtask

  task automatic t_quick();
    ex_n = 0; ex(0, 8'hA0); ex(4, 0);
    run(3'd0, 8'hA0, 0, 0, 0, 0); chk_trace("R2 R1 quick write");
    ex_n = 0; ex(0, 8'hA1); ex(4, 0);
    run(3'd0, 8'hA1, 0, 0, 0, 0); chk_trace("R2 quick read direction bit");
  endtask

  task automatic t_byte();
    rx_mem[0] = 8'h5A;
    ex_n = 0; ex(0, 8'h91); ex(2, 0); ex(3, 0); ex(4, 0);
    run(3'd1, 8'h91, 8'h33, 0, 0, 0); chk_trace("R12 R6 byte read");
    chk(data0_o == 8'h5A, "R12 byte read data0", data0_o, 8'h5A);
    ex_n = 0; ex(0, 8'h90); ex(1, 8'h33); ex(4, 0);
    run(3'd1, 8'h90, 8'h33, 0, 0, 0); chk_trace("R1 byte send");
    rx_mem[0] = 8'hC3;
    ex_n = 0; ex(0, 8'h90); ex(1, 8'h44); ex(0, 8'h91); ex(2, 0); ex(3, 0); ex(4, 0);
    run(3'd2, 8'h91, 8'h44, 0, 0, 0); chk_trace("R2 byte-data read restart");
    chk(data0_o == 8'hC3, "R12 byte-data read data0", data0_o, 8'hC3);
  endtask

  task automatic t_word();
    ex_n = 0; ex(0, 8'h60); ex(1, 8'h12); ex(1, 8'hCD); ex(1, 8'hAB); ex(4, 0);
    run(3'd3, 8'h60, 8'h12, 8'hCD, 8'hAB, 0); chk_trace("R3 word write order");
    rx_mem[0] = 8'h11; rx_mem[1] = 8'h22;
    ex_n = 0; ex(0, 8'h60); ex(1, 8'h12); ex(0, 8'h61); ex(2, 0); ex(2, 0); ex(3, 0); ex(4, 0);
    run(3'd3, 8'h61, 8'h12, 0, 0, 0); chk_trace("R12 word read");
    chk(data0_o == 8'h11 && data1_o == 8'h22, "R12 word read result", {data1_o, data0_o}, 16'h2211);
    rx_mem[0] = 8'h7E; rx_mem[1] = 8'h01;
    ex_n = 0; ex(0, 8'h60); ex(1, 8'h05); ex(1, 8'h34); ex(1, 8'h56);
    ex(0, 8'h61); ex(2, 0); ex(2, 0); ex(3, 0); ex(4, 0);
    run(3'd4, 8'h60, 8'h05, 8'h34, 8'h56, 0); chk_trace("R12 process call");
    chk(data0_o == 8'h7E && data1_o == 8'h01, "R12 process call result", {data1_o, data0_o}, 16'h017E);
  endtask

  task automatic t_blk_write();
    buf_wr(0, 8'hD0); buf_wr(1, 8'hD1); buf_wr(2, 8'hD2);
    ex_n = 0; ex(0, 8'h58); ex(1, 8'h20); ex(1, 8'h03); ex(1, 8'hD0); ex(1, 8'hD1); ex(1, 8'hD2); ex(4, 0);
    run(3'd5, 8'h58, 8'h20, 8'h03, 0, 0); chk_trace("R8 block write with length");
    ex_n = 0; ex(0, 8'h58); ex(1, 8'h20); ex(1, 8'hD0); ex(1, 8'hD1); ex(4, 0);
    run(3'd5, 8'h58, 8'h20, 8'h02, 0, 1); chk_trace("R8 block write I2C mode no length");
  endtask

  task automatic t_busy_ignore();
    int w = 0;
    ex_n = 0; ex(0, 8'h58); ex(1, 8'h21); ex(1, 8'h01); ex(1, 8'hD0); ex(4, 0);
    @(negedge clk);
    proto_i = 3'd5; addr_i = 8'h58; cmd_i = 8'h21; data0_i = 1; i2c_mode_i = 0;
    tr_n = 0; start_i = 1; @(negedge clk); start_i = 0;
    @(negedge clk); proto_i = 3'd7; start_i = 1; @(negedge clk); start_i = 0;
    while (!done_o && w < 2000) begin @(negedge clk); w++; end
    repeat (4) @(negedge clk);
    chk_trace("R11 start while busy ignored");
    chk(!dev_err_o && !busy_o, "R11 second launch had no effect", {dev_err_o, busy_o}, 0);
  endtask

  task automatic t_blk_read();
    logic [7:0] v;
    rx_mem[0] = 8'd4; for (int i = 0; i < 4; i++) rx_mem[1+i] = 8'hA0 + 8'(i);
    ex_n = 0; ex(0, 8'h40); ex(1, 8'h09); ex(0, 8'h41); ex(2, 0);
    for (int i = 0; i < 4; i++) ex(2, 0);
    ex(3, 0); ex(4, 0);
    run(3'd5, 8'h41, 8'h09, 0, 0, 0); chk_trace("R5 block read sequence");
    chk(data0_o == 8'd4, "R5 block read length in data0", data0_o, 4);
    buf_rd(3, v); chk(v == 8'hA3, "R5 block read buffer entry 3", v, 8'hA3);
    buf_rd(0, v); chk(v == 8'hA0, "R5 block read buffer entry 0", v, 8'hA0);
    rx_mem[0] = 8'd40;
    ex_n = 0; ex(0, 8'h40); ex(1, 8'h09); ex(0, 8'h41); ex(2, 0); ex(3, 0); ex(4, 0);
    run(3'd5, 8'h41, 8'h09, 0, 0, 0); chk_trace("R6 oversize length treated as zero");
    chk(data0_o == 8'd0, "R6 oversize length data0", data0_o, 0);
    for (int i = 0; i < 32; i++) rx_mem[i] = 8'h10 + 8'(i);
    ex_n = 0; ex(0, 8'h40); ex(1, 8'h0A); ex(0, 8'h41);
    for (int i = 0; i < 32; i++) ex(2, 0);
    ex(3, 0); ex(4, 0);
    run(3'd5, 8'h41, 8'h0A, 0, 0, 1); chk_trace("R9 I2C mode block read");
    chk(data0_o == 8'd32, "R9 I2C mode count", data0_o, 32);
    buf_rd(31, v); chk(v == 8'h2F, "R9 I2C mode last byte stored", v, 8'h2F);
  endtask

  task automatic t_i2c_blk();
    logic [7:0] v;
    rx_mem[0] = 8'h71; rx_mem[1] = 8'h72; rx_mem[2] = 8'h73;
    ex_n = 0; ex(0, 8'h30); ex(1, 8'h77); ex(0, 8'h31); ex(2, 0); ex(2, 0); ex(2, 0); ex(3, 0); ex(4, 0);
    run(3'd6, 8'h31, 8'hEE, 8'd3, 8'h77, 0); chk_trace("R7 I2C block read uses data1 as command");
    chk(data0_o == 8'd3, "R7 count in data0", data0_o, 3);
    buf_rd(2, v); chk(v == 8'h73, "R7 stored byte 2", v, 8'h73);
    run(3'd6, 8'h31, 8'hEE, 8'd50, 8'h77, 0);
    chk(tr_n == 3 + 32 + 2, "R7 count capped at 32", tr_n, 37);
    chk(data0_o == 8'd32, "R7 capped count data0", data0_o, 32);
    run(3'd6, 8'h30, 8'hEE, 8'd3, 8'h77, 0);
    chk(tr_n == 0 && dev_err_o, "R7 write form gives device error", {tr_n[7:0], 7'd0, dev_err_o}, 1);
  endtask

  task automatic t_err_preset();
    run(3'd0, 8'hA0, 0, 0, 0, 0);
    chk(tr_n == 0 && dev_err_o, "R4 preset error blocks bus", {tr_n[7:0], 7'd0, dev_err_o}, 1);
    clear_err();
    chk(!dev_err_o, "R4 clear", dev_err_o, 0);
    run(3'd7, 8'hA0, 0, 0, 0, 0);
    chk(tr_n == 0 && dev_err_o, "R1 invalid code", {tr_n[7:0], 7'd0, dev_err_o}, 1);
    clear_err();
  endtask

  task automatic t_nack();
    nack_start = 1;
    ex_n = 0; ex(0, 8'h24); ex(4, 0);
    run(3'd2, 8'h24, 8'h01, 8'h02, 0, 0); chk_trace("R10 address nack then stop");
    chk(dev_err_o, "R10 nack sets device error", dev_err_o, 1);
    nack_start = 0;
    clear_err();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_quick();
    t_byte();
    t_word();
    t_blk_write();
    t_busy_ignore();
    t_blk_read();
    t_i2c_blk();
    t_err_preset();
    t_nack();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule